// File: doc/BRIEF.md
# DMA Channel Handshake and Check Unit

This block is the control and pin-facing front end of a single DMA channel. Software programs one 32-bit control word over a simple write-strobe register bus. The block reads fields from that word to decide whether the external request pin is in use and which level counts as active on it. It sets the active level of the acknowledge pin, and it sets the width and destination of the terminal-count pulse. The address datapath and the bus master sit outside and connect through the strobes and the low address bits.

A request taken from the pin is corrected for polarity and passed through a two-flop synchronizer before it appears as an internal active-high request. A one-cycle done strobe starts an active-low terminal-count pulse on either the read-side or the write-side output. The read-back of the control word also carries live alignment flags for the source and destination base addresses, checked against the selected transfer width. It also carries a sticky transfer-failure flag, which can raise an interrupt.

Top module: `chan_hs_front`

## Requirements
- R1: After reset the control word reads 0, both terminal-count outputs are high, and `req_o` and `irq_o` are low.
- R2: A write stores every bit except 31, 22, 21 and 20. Bit 31 always reads 0. Writes to bits 22 and 21 have no effect on their read value.
- R3: The request is enabled only when the mode field [3:2] is non-zero and the request-select field [27:26] equals 01. In every other case `req_o` stays low.
- R4: Bit 25 selects the pin polarity (0 = active low, 1 = active high). An active pin level appears on `req_o` at the second rising edge after it is applied.
- R5: Bit 24 selects the acknowledge polarity. With 0, `ack_pin` is the inverse of `ack_i`. With 1, it equals `ack_i`.
- R6: A `done_i` strobe drives the selected terminal-count output low for exactly N cycles, where N is field [30:28]. An N of 0 gives one cycle.
- R7: Bit 23 steers the pulse: 0 selects `rd_tc_n`, 1 selects `wr_tc_n`. The other output stays high and the two are never low together.
- R8: Field [13:12] is the transfer width. With 10, any non-zero address bits [1:0] set the flag. With 01, address bit 0 set sets the flag. Widths 00 and 11 never flag. Source errors read in bit 22 and destination errors in bit 21, both live.
- R9: `xfer_fail_i` sets bit 20 at the next edge. Writing 1 to bit 20 clears it. A failure in the same cycle as a clear leaves the bit set.
- R10: `irq_o` is high exactly when bit 20 and the enable bit 19 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read-back with live flags |
| src_addr_lo | input | 2 | Low bits of the source base address |
| dst_addr_lo | input | 2 | Low bits of the destination base address |
| ext_req_pin | input | 1 | External request pin, asynchronous |
| req_o | output | 1 | Synchronized active-high request |
| ack_i | input | 1 | Internal active-high acknowledge |
| ack_pin | output | 1 | Polarity-adjusted acknowledge pin |
| done_i | input | 1 | One-cycle transfer-done strobe |
| rd_tc_n | output | 1 | Read-side terminal-count, active low |
| wr_tc_n | output | 1 | Write-side terminal-count, active low |
| xfer_fail_i | input | 1 | Transfer-failure report |
| irq_o | output | 1 | Channel interrupt |

## Verification
Control fields take effect at the edge that accepts the write. The alignment flags and `ack_pin` are combinational, so the bench reads them at the falling edge after the write. A pin level reaches `req_o` two rising edges after it is applied, and the bench checks that it is still low after one edge and high after the second. The terminal-count output goes low at the edge that takes `done_i`. The bench counts low samples on each falling edge over a window longer than seven cycles and also checks that the other output never drops. The failure flag and the interrupt are checked one edge after the strobe or the write.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam int CW_W      = 32;
  localparam int TCW_W     = 3;
  localparam int B_ZERO    = 31;
  localparam int B_TCW_LO  = 28;
  localparam int B_RSEL_LO = 26;
  localparam int B_REQPOL  = 25;
  localparam int B_ACKPOL  = 24;
  localparam int B_ROUTE   = 23;
  localparam int B_SERR    = 22;
  localparam int B_DERR    = 21;
  localparam int B_FAIL    = 20;
  localparam int B_IEN     = 19;
  localparam int B_XW_LO   = 12;
  localparam int B_MODE_LO = 2;

  typedef struct packed {
    logic [TCW_W-1:0] tc_w;
    logic [1:0]       req_sel;
    logic             req_pol;
    logic             ack_pol;
    logic             tc_route;
    logic             irq_en;
    logic [1:0]       xfer_w;
    logic [1:0]       mode;
  } ctrl_t;
endpackage

// File: rtl/chs_ctrl_reg.sv
module chs_ctrl_reg
  import chs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW_W-1:0] wdata,
  input  logic            fail_i,
  input  logic            src_err,
  input  logic            dst_err,
  output logic [CW_W-1:0] rdata,
  output ctrl_t           ctrl,
  output logic            fail_flag
);
  localparam logic [CW_W-1:0] RW_MASK =
    ~((CW_W'(1) << B_ZERO) | (CW_W'(1) << B_SERR) |
      (CW_W'(1) << B_DERR) | (CW_W'(1) << B_FAIL));

  logic [CW_W-1:0] store_q, store_d;
  logic            fail_q, fail_d;

  always_comb begin
    store_d = store_q;
    if (wr_en) store_d = wdata & RW_MASK;
  end

  always_comb begin
    fail_d = fail_q;
    if (wr_en && wdata[B_FAIL]) fail_d = 1'b0;
    if (fail_i)                 fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      if (wr_en) store_q <= store_d;
      fail_q <= fail_d;
    end
  end

  always_comb begin
    rdata         = store_q;
    rdata[B_SERR] = src_err;
    rdata[B_DERR] = dst_err;
    rdata[B_FAIL] = fail_q;
  end

  assign ctrl.tc_w     = store_q[B_TCW_LO +: TCW_W];
  assign ctrl.req_sel  = store_q[B_RSEL_LO +: 2];
  assign ctrl.req_pol  = store_q[B_REQPOL];
  assign ctrl.ack_pol  = store_q[B_ACKPOL];
  assign ctrl.tc_route = store_q[B_ROUTE];
  assign ctrl.irq_en   = store_q[B_IEN];
  assign ctrl.xfer_w   = store_q[B_XW_LO +: 2];
  assign ctrl.mode     = store_q[B_MODE_LO +: 2];
  assign fail_flag     = fail_q;

  // R9: a reported failure is always visible one edge later
  assert_fail_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_i |=> rdata[B_FAIL]);
  // R2: the top bit never reads back as one
  assert_top_bit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rdata[B_ZERO]);
endmodule

// File: rtl/chs_req_sync.sv
module chs_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol_high,
  input  logic enable,
  output logic req
);
  localparam int LAST = STAGES - 1;

  logic              raw;
  logic [STAGES-1:0] sync_q, sync_d;

  assign raw = pol_high ? pin : ~pin;

  generate
    if (STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], raw};
    end else begin : g_single
      assign sync_d = raw;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign req = enable & sync_q[LAST];
endmodule

// File: rtl/chs_tc_pulse.sv
module chs_tc_pulse #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic [W-1:0] width,
  output logic         active
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (done) begin
      cnt_en = 1'b1;
      cnt_d  = (width == '0) ? W'(1) : width;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R6: a done strobe always starts a pulse
  assert_done_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> active);
  // R6: an idle counter stays idle without a strobe
  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !done) |=> !active);
endmodule

// File: rtl/chs_align_chk.sv
module chs_align_chk (
  input  logic [1:0] xfer_w,
  input  logic [1:0] addr_lo,
  output logic       err
);
  always_comb begin
    unique case (xfer_w)
      2'b10:   err = (addr_lo != 2'b00);
      2'b01:   err = addr_lo[0];
      default: err = 1'b0;
    endcase
  end
endmodule

// File: rtl/chan_hs_front.sv
module chan_hs_front
  import chs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [CW_W-1:0] reg_wdata,
  output logic [CW_W-1:0] reg_rdata,
  input  logic [1:0]      src_addr_lo,
  input  logic [1:0]      dst_addr_lo,
  input  logic            ext_req_pin,
  output logic            req_o,
  input  logic            ack_i,
  output logic            ack_pin,
  input  logic            done_i,
  output logic            rd_tc_n,
  output logic            wr_tc_n,
  input  logic            xfer_fail_i,
  output logic            irq_o
);
  localparam int NCHK = 2;

  logic [1:0] rst_q;
  logic       rst_li;
  ctrl_t      ctrl;
  logic       fail_flag;
  logic       tc_active;
  logic       req_en;
  logic [NCHK-1:0] align_err;
  logic [1:0] chk_addr [NCHK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_li = rst_q[1];

  chs_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_li), .wr_en(reg_wr), .wdata(reg_wdata),
    .fail_i(xfer_fail_i), .src_err(align_err[0]), .dst_err(align_err[1]),
    .rdata(reg_rdata), .ctrl(ctrl), .fail_flag(fail_flag)
  );

  assign chk_addr[0] = src_addr_lo;
  assign chk_addr[1] = dst_addr_lo;

  generate
    for (genvar gi = 0; gi < NCHK; gi++) begin : g_align
      chs_align_chk u_chk (
        .xfer_w(ctrl.xfer_w), .addr_lo(chk_addr[gi]), .err(align_err[gi])
      );
    end
  endgenerate

  assign req_en = (ctrl.mode != 2'b00) && (ctrl.req_sel == 2'b01);

  chs_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_li), .pin(ext_req_pin),
    .pol_high(ctrl.req_pol), .enable(req_en), .req(req_o)
  );

  chs_tc_pulse #(.W(TCW_W)) u_tc (
    .clk(clk), .rst_n(rst_li), .done(done_i),
    .width(ctrl.tc_w), .active(tc_active)
  );

  assign rd_tc_n = ~(tc_active & ~ctrl.tc_route);
  assign wr_tc_n = ~(tc_active &  ctrl.tc_route);
  assign ack_pin = ctrl.ack_pol ? ack_i : ~ack_i;
  assign irq_o   = fail_flag & ctrl.irq_en;

  // R7: the two terminal-count outputs are never low together
  assert_tc_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_li)
    !(!rd_tc_n && !wr_tc_n));
  // R3: with mode 00 no request can come through
  assert_mode_off_no_req_R3: assert property (@(posedge clk) disable iff (!rst_li)
    (ctrl.mode == 2'b00) |-> !req_o);
  // R10: interrupt only with the failure flag readable as set
  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_li)
    irq_o |-> reg_rdata[B_FAIL]);
  // R8: word-width misalignment on the source is flagged
  assert_src_word_err_R8: assert property (@(posedge clk) disable iff (!rst_li)
    (ctrl.xfer_w == 2'b10 && src_addr_lo != 2'b00) |-> reg_rdata[B_SERR]);
endmodule

// File: tb/test_chan_hs_front.sv
module test_chan_hs_front;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  src_addr_lo, dst_addr_lo;
  logic        ext_req_pin, req_o, ack_i, ack_pin, done_i;
  logic        rd_tc_n, wr_tc_n, xfer_fail_i, irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  chan_hs_front i_chan_hs_front (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_addr_lo(src_addr_lo), .dst_addr_lo(dst_addr_lo),
    .ext_req_pin(ext_req_pin), .req_o(req_o), .ack_i(ack_i), .ack_pin(ack_pin),
    .done_i(done_i), .rd_tc_n(rd_tc_n), .wr_tc_n(wr_tc_n),
    .xfer_fail_i(xfer_fail_i), .irq_o(irq_o)
  );

  // {xfer width, src lo, dst lo, expected src flag, expected dst flag}
  localparam logic [7:0] ALIGN_TBL [12] = '{
    {2'b00, 2'b11, 2'b01, 1'b0, 1'b0},
    {2'b11, 2'b11, 2'b10, 1'b0, 1'b0},
    {2'b01, 2'b00, 2'b10, 1'b0, 1'b0},
    {2'b01, 2'b01, 2'b11, 1'b1, 1'b1},
    {2'b01, 2'b10, 2'b01, 1'b0, 1'b1},
    {2'b01, 2'b11, 2'b00, 1'b1, 1'b0},
    {2'b10, 2'b00, 2'b00, 1'b0, 1'b0},
    {2'b10, 2'b10, 2'b00, 1'b1, 1'b0},
    {2'b10, 2'b01, 2'b00, 1'b1, 1'b0},
    {2'b10, 2'b00, 2'b11, 1'b0, 1'b1},
    {2'b10, 2'b11, 2'b10, 1'b1, 1'b1},
    {2'b00, 2'b00, 2'b00, 1'b0, 1'b0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] d);
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tc_run(input int w, input logic route);
    int lows = 0;
    int other = 0;
    int exp_w;
    exp_w = (w == 0) ? 1 : w;
    wr_ctrl((32'(w) << 28) | (32'(route) << 23));
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (route ? !wr_tc_n : !rd_tc_n) lows++;
      if (route ? !rd_tc_n : !wr_tc_n) other++;
      @(negedge clk);
    end
    chk("R6 pulse width", 32'(lows), 32'(exp_w));
    chk("R7 unselected output", 32'(other), 32'd0);
  endtask

  task automatic req_case(input logic [1:0] mode, input logic [1:0] sel, input logic exp);
    wr_ctrl((32'(sel) << 26) | (32'd1 << 25) | (32'(mode) << 2));
    wait_cyc(3);
    chk("R3 request enable", 32'(req_o), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    src_addr_lo = '0; dst_addr_lo = '0;
    ext_req_pin = 1'b1; ack_i = 1'b0; done_i = 1'b0; xfer_fail_i = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    chk("R1 control word", reg_rdata, 32'h0);
    chk("R1 read tc", 32'(rd_tc_n), 32'd1);
    chk("R1 write tc", 32'(wr_tc_n), 32'd1);
    chk("R1 request", 32'(req_o), 32'd0);
    chk("R1 interrupt", 32'(irq_o), 32'd0);

    // R8 alignment table
    foreach (ALIGN_TBL[k]) begin
      src_addr_lo = ALIGN_TBL[k][5:4];
      dst_addr_lo = ALIGN_TBL[k][3:2];
      wr_ctrl(32'(ALIGN_TBL[k][7:6]) << 12);
      chk("R8 source flag", 32'(reg_rdata[22]), 32'(ALIGN_TBL[k][1]));
      chk("R8 destination flag", 32'(reg_rdata[21]), 32'(ALIGN_TBL[k][0]));
    end
    src_addr_lo = '0; dst_addr_lo = '0;

    // R2 writable mask and read-only bits
    wr_ctrl(32'hFFFF_FFFF);
    chk("R2 readback mask", reg_rdata, 32'h7F8F_FFFF);
    wr_ctrl(32'h0);
    chk("R2 cleared", reg_rdata, 32'h0);

    // R3 request decode
    ext_req_pin = 1'b1;
    req_case(2'b00, 2'b01, 1'b0);
    req_case(2'b01, 2'b00, 1'b0);
    req_case(2'b10, 2'b10, 1'b0);
    req_case(2'b11, 2'b11, 1'b0);
    req_case(2'b01, 2'b01, 1'b1);
    req_case(2'b11, 2'b01, 1'b1);

    // R4 polarity and synchronizer latency
    ext_req_pin = 1'b0;
    wr_ctrl((32'd1 << 26) | (32'd1 << 25) | (32'd1 << 2));
    wait_cyc(3);
    chk("R4 high-active idle", 32'(req_o), 32'd0);
    ext_req_pin = 1'b1;
    @(negedge clk);
    chk("R4 one edge later", 32'(req_o), 32'd0);
    @(negedge clk);
    chk("R4 two edges later", 32'(req_o), 32'd1);
    wr_ctrl((32'd1 << 26) | (32'd1 << 2));
    wait_cyc(3);
    chk("R4 low-active with pin high", 32'(req_o), 32'd0);
    ext_req_pin = 1'b0;
    @(negedge clk);
    chk("R4 low-active one edge", 32'(req_o), 32'd0);
    @(negedge clk);
    chk("R4 low-active two edges", 32'(req_o), 32'd1);
    ext_req_pin = 1'b1;

    // R5 acknowledge polarity
    wr_ctrl(32'h0);
    ack_i = 1'b1; #1;
    chk("R5 low-active ack on", 32'(ack_pin), 32'd0);
    ack_i = 1'b0; #1;
    chk("R5 low-active ack off", 32'(ack_pin), 32'd1);
    @(negedge clk);
    wr_ctrl(32'd1 << 24);
    ack_i = 1'b1; #1;
    chk("R5 high-active ack on", 32'(ack_pin), 32'd1);
    ack_i = 1'b0; #1;
    chk("R5 high-active ack off", 32'(ack_pin), 32'd0);
    @(negedge clk);

    // R6 / R7 terminal-count pulse
    tc_run(0, 1'b0);
    tc_run(1, 1'b0);
    tc_run(3, 1'b0);
    tc_run(7, 1'b0);
    tc_run(5, 1'b1);
    tc_run(2, 1'b1);

    // R9 / R10 failure flag and interrupt
    wr_ctrl(32'h0);
    xfer_fail_i = 1'b1;
    @(negedge clk);
    xfer_fail_i = 1'b0;
    chk("R9 flag set", 32'(reg_rdata[20]), 32'd1);
    chk("R10 masked", 32'(irq_o), 32'd0);
    wr_ctrl(32'd1 << 19);
    chk("R9 write 0 keeps flag", 32'(reg_rdata[20]), 32'd1);
    chk("R10 enabled", 32'(irq_o), 32'd1);
    wr_ctrl((32'd1 << 19) | (32'd1 << 20));
    chk("R9 write 1 clears", 32'(reg_rdata[20]), 32'd0);
    chk("R10 drops", 32'(irq_o), 32'd0);
    xfer_fail_i = 1'b1;
    wr_ctrl((32'd1 << 19) | (32'd1 << 20));
    xfer_fail_i = 1'b0;
    chk("R9 set wins over clear", 32'(reg_rdata[20]), 32'd1);
    chk("R10 after set wins", 32'(irq_o), 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule